// File: doc/BRIEF.md
# Lane Swizzle Crossbar

The lane swizzle crossbar takes one row of lane data and a decoded swizzle command, and returns for each output lane the word read from a source lane. The mode in the command chooses the rule that picks that source lane. There are five rules:

- a per-quad permutation;
- a per-bit transform of the lane id;
- a broadcast inside aligned groups;
- an exchange of neighbouring groups;
- a reversal inside aligned groups.

It sits between a register read stage and a write-back stage. Each valid command produces one registered result one clock later.

A command that cannot be carried out raises an error flag next to the result, and the lanes pass through unchanged. This covers a group size that is not allowed, a broadcast index outside its group, and an undefined mode code. The all-zero command is a legal default. It makes every lane read the first lane of its own quad.

Top module: `lsx_swizzle_xbar`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `out_err` and all of `out_data` are zero after that edge.
- R2: `out_valid` equals `in_valid` from one edge earlier. When `in_valid` was low, `out_data` keeps its previous value.
- R3: Mode code 0 is quad permute. `cmd_quad_sel[2k+1:2k]` names the source for quad position k. Output lane L reads lane 4*(L/4) + sel[L%4].
- R4: Mode code 1 is bitmask. Bit b of the source id is set by `cmd_bit_code[2b+1:2b]`: 0 gives 0, 1 gives 1, 2 copies lane-id bit b, and 3 inverts it.
- R5: Mode code 2 is broadcast. `cmd_size` is one of 2, 4, 8, 16, 32. Every lane reads lane size*(L/size) + `cmd_index`.
- R6: In broadcast mode, `cmd_index` >= `cmd_size` sets `out_err`, and every lane passes its own input through.
- R7: Mode code 3 is swap. `cmd_size` is one of 1, 2, 4, 8, 16. A lane in an even group of that size reads lane L+size, and a lane in an odd group reads lane L-size.
- R8: Mode code 4 is reverse. `cmd_size` is one of 2, 4, 8, 16, 32. Lane L reads the mirrored position within its aligned group.
- R9: A size outside the allowed set of its mode sets `out_err`, and the lanes pass through. This includes 0, values that are not powers of two, and values that are too large.
- R10: Mode codes 5, 6 and 7 set `out_err`, and the lanes pass through.
- R11: An all-zero command makes every lane read lane 4*(L/4), with `out_err` low.
- R12: `out_err` is high only together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command and data present |
| in_data | input | 1024 | Lane L word at bits [32L+31:32L] |
| cmd_mode | input | 3 | Mode code (0 quad, 1 bitmask, 2 broadcast, 3 swap, 4 reverse) |
| cmd_quad_sel | input | 8 | Four 2-bit quad selectors |
| cmd_bit_code | input | 10 | Five 2-bit lane-id bit codes |
| cmd_size | input | 6 | Group size (broadcast, reverse) or swap distance |
| cmd_index | input | 5 | Broadcast lane index within a group |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Command was rejected; data passed through |
| out_data | output | 1024 | Permuted lanes, same packing as `in_data` |

## Verification
The hardest cases are the boundaries of group arithmetic:

- a size of 32, whose five low bits are zero, so the group mask has to wrap to all ones;
- a broadcast index equal to the group size;
- sizes that are in range but are not powers of two.

The stimulus sweeps every legal size of every mode with random lane data. It then sends each neighbouring illegal value (0, 3, 33, and 32 for swap), each undefined mode code, and an index one past the group. Long runs of random commands with idle gaps follow, to test the hold behaviour.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    typedef enum logic [2:0] {
        MODE_QUAD  = 3'd0,
        MODE_BITS  = 3'd1,
        MODE_BCAST = 3'd2,
        MODE_SWAP  = 3'd3,
        MODE_REV   = 3'd4
    } lsx_mode_e;

    typedef enum logic [1:0] {
        BIT_ZERO = 2'd0,
        BIT_ONE  = 2'd1,
        BIT_KEEP = 2'd2,
        BIT_FLIP = 2'd3
    } lsx_bitop_e;

endpackage

// File: rtl/lsx_cmd_check.sv
module lsx_cmd_check
    import lsx_pkg::*;
#(
    parameter int LANES = 32,
    localparam int LW = $clog2(LANES),
    localparam int SW = LW + 1
) (
    input  logic [2:0]    mode_i,
    input  logic [SW-1:0] size_i,
    input  logic [LW-1:0] index_i,
    output logic          err_o
);
    localparam logic [SW-1:0] FULL_W = SW'(LANES);
    localparam logic [SW-1:0] HALF_W = SW'(LANES / 2);

    logic pow2;
    logic grp_ok;
    logic swp_ok;

    always_comb begin
        pow2   = (size_i != '0) && ((size_i & (size_i - SW'(1))) == '0);
        grp_ok = pow2 && (size_i >= SW'(2)) && (size_i <= FULL_W);
        swp_ok = pow2 && (size_i <= HALF_W);
        case (lsx_mode_e'(mode_i))
            MODE_QUAD:  err_o = 1'b0;
            MODE_BITS:  err_o = 1'b0;
            MODE_BCAST: err_o = !grp_ok || ({1'b0, index_i} >= size_i);
            MODE_SWAP:  err_o = !swp_ok;
            MODE_REV:   err_o = !grp_ok;
            default:    err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsx_src_map.sv
module lsx_src_map
    import lsx_pkg::*;
#(
    parameter int LANES   = 32,
    parameter int LANE_ID = 0,
    localparam int LW = $clog2(LANES)
) (
    input  logic [2:0]      mode_i,
    input  logic [7:0]      quad_sel_i,
    input  logic [2*LW-1:0] bit_code_i,
    input  logic [LW-1:0]   size_lo_i,
    input  logic [LW-1:0]   index_i,
    output logic [LW-1:0]   src_o
);
    localparam logic [LW-1:0] LID  = LW'(LANE_ID);
    localparam int            QPOS = 2 * (LANE_ID % 4);

    logic [LW-1:0] mask;
    logic [LW-1:0] bits_src;

    always_comb begin
        // size 32 has zero low bits; the subtraction wraps to an all-ones mask
        mask = size_lo_i - LW'(1);
        for (int i = 0; i < LW; i++) begin
            case (lsx_bitop_e'(bit_code_i[2*i +: 2]))
                BIT_ZERO: bits_src[i] = 1'b0;
                BIT_ONE:  bits_src[i] = 1'b1;
                BIT_KEEP: bits_src[i] = LID[i];
                default:  bits_src[i] = ~LID[i];
            endcase
        end
        case (lsx_mode_e'(mode_i))
            MODE_QUAD:  src_o = {LID[LW-1:2], quad_sel_i[QPOS +: 2]};
            MODE_BITS:  src_o = bits_src;
            MODE_BCAST: src_o = (LID & ~mask) | (index_i & mask);
            MODE_SWAP:  src_o = LID ^ size_lo_i;
            MODE_REV:   src_o = LID ^ mask;
            default:    src_o = LID;
        endcase
    end
endmodule

// File: rtl/lsx_lane_mux.sv
module lsx_lane_mux #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int LW = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] data_i,
    input  logic [LW-1:0]       sel_i,
    output logic [DW-1:0]       word_o
);
    always_comb begin
        word_o = data_i[sel_i*DW +: DW];
    end
endmodule

// File: rtl/lsx_swizzle_xbar.sv
module lsx_swizzle_xbar
    import lsx_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int LW = $clog2(LANES),
    localparam int SW = LW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [LANES*DW-1:0] in_data,
    input  logic [2:0]          cmd_mode,
    input  logic [7:0]          cmd_quad_sel,
    input  logic [2*LW-1:0]     cmd_bit_code,
    input  logic [SW-1:0]       cmd_size,
    input  logic [LW-1:0]       cmd_index,
    output logic                out_valid,
    output logic                out_err,
    output logic [LANES*DW-1:0] out_data
);
    typedef struct packed {
        logic                valid;
        logic                err;
        logic [LANES*DW-1:0] data;
    } lsx_state_t;

    lsx_state_t state_d, state_q;

    logic                cmd_err;
    logic [DW-1:0]       perm_word [LANES];
    logic [LANES*DW-1:0] perm_data;

    lsx_cmd_check #(.LANES(LANES)) u_check (
        .mode_i  (cmd_mode),
        .size_i  (cmd_size),
        .index_i (cmd_index),
        .err_o   (cmd_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] raw_src;
        logic [LW-1:0] use_src;

        lsx_src_map #(.LANES(LANES), .LANE_ID(g)) u_map (
            .mode_i     (cmd_mode),
            .quad_sel_i (cmd_quad_sel),
            .bit_code_i (cmd_bit_code),
            .size_lo_i  (cmd_size[LW-1:0]),
            .index_i    (cmd_index),
            .src_o      (raw_src)
        );

        assign use_src = cmd_err ? LW'(g) : raw_src;

        lsx_lane_mux #(.LANES(LANES), .DW(DW)) u_mux (
            .data_i (in_data),
            .sel_i  (use_src),
            .word_o (perm_word[g])
        );
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            perm_data[l*DW +: DW] = perm_word[l];
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        state_d.err   = in_valid & cmd_err;
        if (in_valid) begin
            state_d.data = perm_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_err   = state_q.err;
    assign out_data  = state_q.data;
endmodule

// File: rtl/lsx_checker.sv
module lsx_checker #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int LW = $clog2(LANES),
    localparam int SW = LW + 1
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [LANES*DW-1:0] in_data,
    input logic [2:0]          cmd_mode,
    input logic [SW-1:0]       cmd_size,
    input logic [LW-1:0]       cmd_index,
    input logic                out_valid,
    input logic                out_err,
    input logic [LANES*DW-1:0] out_data
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !out_valid && !out_err && (out_data == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    assert_bcast_range_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && (cmd_mode == 3'd2) && ({1'b0, cmd_index} >= cmd_size) |=> out_err);

    assert_swap_one_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && (cmd_mode == 3'd3) && (cmd_size == SW'(1))
        |=> out_data[DW-1:0] == $past(in_data[2*DW-1:DW]));

    assert_bad_mode_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && (cmd_mode > 3'd4) |=> out_err && (out_data == $past(in_data)));

    assert_err_gated_R12: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_err);
endmodule

bind lsx_swizzle_xbar lsx_checker #(.LANES(LANES), .DW(DW)) u_lsx_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .cmd_mode  (cmd_mode),
    .cmd_size  (cmd_size),
    .cmd_index (cmd_index),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_data  (out_data)
);

// File: tb/tb_lsx_swizzle_xbar.sv
module tb_lsx_swizzle_xbar;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int DW    = 32;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [LANES*DW-1:0] in_data = '0;
    logic [2:0]          cmd_mode = '0;
    logic [7:0]          cmd_quad_sel = '0;
    logic [9:0]          cmd_bit_code = '0;
    logic [5:0]          cmd_size = '0;
    logic [4:0]          cmd_index = '0;
    logic                out_valid;
    logic                out_err;
    logic [LANES*DW-1:0] out_data;

    int checks = 0;
    int failures = 0;
    string drv_tag = "R1";

    // model state
    logic                m_valid = 1'b0;
    logic                m_err = 1'b0;
    logic [LANES*DW-1:0] m_data = '0;
    string               m_tag = "R1";
    bit                  m_live = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsx_swizzle_xbar #(.LANES(LANES), .DW(DW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .cmd_mode(cmd_mode), .cmd_quad_sel(cmd_quad_sel), .cmd_bit_code(cmd_bit_code),
        .cmd_size(cmd_size), .cmd_index(cmd_index),
        .out_valid(out_valid), .out_err(out_err), .out_data(out_data)
    );

    function automatic bit is_one_of(int v, int lo, int hi);
        for (int s = lo; s <= hi; s = s * 2) if (v == s) return 1'b1;
        return 1'b0;
    endfunction

    // returns -1 when the command is rejected
    function automatic int ref_src(int l, int mode, int q, int bc, int sz, int idx);
        int r;
        case (mode)
            0: return (l / 4) * 4 + ((q >> (2 * (l % 4))) & 3);
            1: begin
                r = 0;
                for (int b = 0; b < 5; b++) begin
                    int bit_in, code, v;
                    bit_in = (l >> b) & 1;
                    code = (bc >> (2 * b)) & 3;
                    v = (code == 0) ? 0 : (code == 1) ? 1 : (code == 2) ? bit_in : 1 - bit_in;
                    r = r + (v << b);
                end
                return r;
            end
            2: begin
                if (!is_one_of(sz, 2, 32) || idx >= sz) return -1;
                return (l / sz) * sz + idx;
            end
            3: begin
                if (!is_one_of(sz, 1, 16)) return -1;
                return (((l / sz) % 2) == 0) ? l + sz : l - sz;
            end
            4: begin
                if (!is_one_of(sz, 2, 32)) return -1;
                return (l / sz) * sz + (sz - 1 - (l % sz));
            end
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        m_live <= 1'b1;
        m_tag  <= drv_tag;
        if (rst) begin
            m_valid <= 1'b0;
            m_err   <= 1'b0;
            m_data  <= '0;
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                int e;
                logic [LANES*DW-1:0] nd;
                e = ref_src(0, int'(cmd_mode), int'(cmd_quad_sel), int'(cmd_bit_code),
                            int'(cmd_size), int'(cmd_index));
                for (int l = 0; l < LANES; l++) begin
                    int s;
                    s = (e < 0) ? l : ref_src(l, int'(cmd_mode), int'(cmd_quad_sel),
                                              int'(cmd_bit_code), int'(cmd_size), int'(cmd_index));
                    nd[l*DW +: DW] = in_data[s*DW +: DW];
                end
                m_err  <= (e < 0);
                m_data <= nd;
            end else begin
                m_err <= 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            checks++;
            if (out_valid !== m_valid || out_err !== m_err) begin
                failures++;
                $display("FAIL %s/R2/R12 valid=%b err=%b expected valid=%b err=%b",
                         m_tag, out_valid, out_err, m_valid, m_err);
            end
            checks++;
            if (out_data !== m_data) begin
                failures++;
                for (int l = 0; l < LANES; l++)
                    if (out_data[l*DW +: DW] !== m_data[l*DW +: DW]) begin
                        $display("FAIL %s data lane %0d got %h expected %h", m_tag, l,
                                 out_data[l*DW +: DW], m_data[l*DW +: DW]);
                        break;
                    end
            end
        end
    end

    task automatic rand_data();
        for (int l = 0; l < LANES; l++) in_data[l*DW +: DW] = $urandom;
    endtask

    task automatic send(int mode, int q, int bc, int sz, int idx, string tag);
        @(negedge clk);
        drv_tag      = tag;
        in_valid     = 1'b1;
        cmd_mode     = 3'(mode);
        cmd_quad_sel = 8'(q);
        cmd_bit_code = 10'(bc);
        cmd_size     = 6'(sz);
        cmd_index    = 5'(idx);
        rand_data();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drv_tag  = "R2_hold";
            in_valid = 1'b0;
            cmd_mode = 3'($urandom);
            cmd_size = 6'($urandom);
            rand_data();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 default command, then R3 quad patterns
        send(0, 0, 0, 0, 0, "R11");
        send(0, 8'hE4, 0, 0, 0, "R3");
        send(0, 8'h1B, 0, 0, 0, "R3");
        send(0, 8'hFF, 0, 0, 0, "R3");
        // R4 bitmask: keep all, flip all, force, mixed
        send(1, 0, 10'h2AA, 0, 0, "R4");
        send(1, 0, 10'h3FF, 0, 0, "R4");
        send(1, 0, 10'h155, 0, 0, "R4");
        send(1, 0, 10'h0E4, 0, 0, "R4");
        // R5 / R6 broadcast
        for (int s = 2; s <= 32; s = s * 2) begin
            send(2, 0, 0, s, 0, "R5");
            send(2, 0, 0, s, s - 1, "R5");
            if (s < 32) send(2, 0, 0, s, s, "R6");
        end
        // R7 swap, R8 reverse
        for (int s = 1; s <= 16; s = s * 2) send(3, 0, 0, s, 0, "R7");
        for (int s = 2; s <= 32; s = s * 2) send(4, 0, 0, s, 0, "R8");
        idle(3);
        // R9 illegal sizes
        send(2, 0, 0, 0, 0, "R9");
        send(2, 0, 0, 3, 1, "R9");
        send(2, 0, 0, 33, 0, "R9");
        send(3, 0, 0, 0, 0, "R9");
        send(3, 0, 0, 32, 0, "R9");
        send(3, 0, 0, 6, 0, "R9");
        send(4, 0, 0, 1, 0, "R9");
        send(4, 0, 0, 12, 0, "R9");
        // R10 undefined modes
        for (int m = 5; m < 8; m++) send(m, 8'hE4, 10'h3FF, 4, 1, "R10");
        idle(2);
        // mixed random traffic with gaps
        for (int i = 0; i < 400; i++) begin
            int sz;
            sz = ($urandom % 4 == 0) ? int'($urandom % 40) : (1 << ($urandom % 6));
            if ($urandom % 4 == 0) idle(1);
            else send(int'($urandom % 8), int'($urandom % 256), int'($urandom % 1024),
                      sz, int'($urandom % 32), "R3_R10_rand");
        end
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        drv_tag = "R1";
        in_valid = 1'b1;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule